// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when the contents of a volatile SRAM are copied into nonvolatile cells (a store) and when they are copied back (a recall). It watches a low-supply comparator, an active-low hardware store request, single-cycle software store and recall strobes, and the SRAM write enable. From these it issues one-cycle start pulses to the nonvolatile array, a lockout that blocks SRAM access while an operation runs, and a busy flag. Every duration is a clock-cycle count set by a parameter.

A store only happens when at least one SRAM write has landed since the last store or recall finished; otherwise the request is dropped and the block stays ready. A hardware store request does not lock the SRAM at once. It first opens a grace window in which reads and writes still go through, so a cycle already in flight can finish, and only then starts the store. When the supply falls, the block stores if needed and then holds the SRAM locked until the supply comes back. When the supply rises it runs a timed power-up recall.

Top module: `nv_store_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy` and `io_lock` are 1 and both start pulses are 0.
- R2: In the power-up recall state, the recall timer is held while `low_vdd` is 1. At the first clock edge that samples `low_vdd` at 0, `recall_start` pulses for one cycle. `busy` and `io_lock` fall at the `PWRUP_CYC`-th consecutive edge that samples `low_vdd` at 0. If `low_vdd` returns to 1, the count restarts, and so does the pulse.
- R3: A write (`sram_we` = 1 at an edge while `io_lock` = 0) marks the SRAM dirty. A completed store or recall clears the mark. Writes attempted while `io_lock` = 1 have no effect.
- R4: A `sw_store` strobe sampled in the ready state while dirty makes `store_start` pulse in the next cycle. `busy` and `io_lock` then stay 1 for exactly `STORE_CYC` cycles.
- R5: Any store request (software, hardware or low supply) taken while the SRAM is clean starts no store. For software and hardware requests, `busy` stays 0.
- R6: A `sw_recall` strobe sampled in the ready state makes `recall_start` pulse in the next cycle. `busy` and `io_lock` then stay 1 for exactly `RECALL_CYC` cycles.
- R7: `hw_store_n` counts as a request only after it has been sampled low on `HW_MIN_CYC` consecutive edges. A low stretch produces at most one request.
- R8: A qualified hardware request taken while dirty starts, one edge later, a grace window of `GRACE_CYC` cycles with `busy` = 1 and `io_lock` = 0. After the window, `store_start` pulses and a `STORE_CYC` store follows.
- R9: `low_vdd` = 1 in the ready state starts a store if dirty, or goes straight to the locked power-up state if clean. After that store, if `low_vdd` is still 1, the block stays busy and locked until the power-up recall of R2 completes.
- R10: A hardware request that qualifies while the block is busy is held. It is evaluated in the first ready cycle, where it is dropped if the SRAM is clean.
- R11: `sw_store` and `sw_recall` are ignored in every state other than ready. No store starts in the cycle after one in which `io_lock` is 1.
- R12: In the ready state the triggers are taken in this order: low supply, then hardware request, then software store, then software recall.
- R13: `store_start` and `recall_start` are never 1 together, and each lasts one cycle. `io_lock` = 1 implies `busy` = 1. `busy` is 0 only in the ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_vdd | input | 1 | Supply comparator, 1 = supply below trigger level |
| hw_store_n | input | 1 | Hardware store request, active low |
| sw_store | input | 1 | Software store strobe |
| sw_recall | input | 1 | Software recall strobe |
| sram_we | input | 1 | SRAM write activity |
| io_lock | output | 1 | SRAM access lockout |
| busy | output | 1 | 1 whenever not in the ready state |
| store_start | output | 1 | One-cycle store start pulse |
| recall_start | output | 1 | One-cycle recall start pulse |

## Verification
A software strobe sampled at an edge produces its start pulse and raises `busy` in the cycle right after that edge. A hardware request needs `HW_MIN_CYC` low samples plus one more edge before the grace window opens. The power-up recall pulse follows the first edge that samples the supply as good. Every operation then holds `busy` for an exact cycle count. The bench drives inputs on falling edges and samples on the next falling edge, so each expected count is a whole number of edges after the trigger. Lengths are measured by counting busy, locked and grace samples. A port-level monitor keeps its own dirty mark from writes and lock releases, and checks that every store pulse was preceded by a write.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_READY  = 3'd1,
    ST_GRACE  = 3'd2,
    ST_STORE  = 3'd3,
    ST_RECALL = 3'd4
  } nvs_state_e;

  function automatic logic locks_io(input nvs_state_e s);
    return (s == ST_PWRUP) || (s == ST_STORE) || (s == ST_RECALL);
  endfunction

endpackage

// File: rtl/nvs_hw_req_filter.sv
module nvs_hw_req_filter #(
  parameter int MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_n,
  output logic req
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      req     <= 1'b0;
    end else begin
      req <= !hw_n && (low_cnt == LAST);
      if (hw_n)
        low_cnt <= '0;
      else if (low_cnt != SAT)
        low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nvs_dirty_flag.sv
module nvs_dirty_flag (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic lock,
  input  logic clr,
  output logic dirty
);
  always_ff @(posedge clk) begin
    if (rst)
      dirty <= 1'b0;
    else if (clr)
      dirty <= 1'b0;
    else if (wr && !lock)
      dirty <= 1'b1;
  end
endmodule

// File: rtl/nvs_op_timer.sv
module nvs_op_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expired
);
  always_ff @(posedge clk) begin
    if (rst)
      count <= W'(RST_VAL);
    else if (load)
      count <= load_val;
    else if (count != '0)
      count <= count - 1'b1;
  end

  assign expired = (count == '0);
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
  parameter int GRACE_CYC  = 6,
  parameter int STORE_CYC  = 20,
  parameter int RECALL_CYC = 12,
  parameter int PWRUP_CYC  = 16,
  parameter int HW_MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic low_vdd,
  input  logic hw_store_n,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic sram_we,
  output logic io_lock,
  output logic busy,
  output logic store_start,
  output logic recall_start
);
  import nvs_pkg::*;

  localparam int MAX_GS  = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
  localparam int MAX_RP  = (RECALL_CYC > PWRUP_CYC) ? RECALL_CYC : PWRUP_CYC;
  localparam int MAX_CYC = (MAX_GS > MAX_RP) ? MAX_GS : MAX_RP;
  localparam int TW      = $clog2(MAX_CYC + 1);

  nvs_state_e    state_q, state_n;
  logic          hw_req, hw_pend_q, hw_any, pend_clr;
  logic          dirty_q, op_done, pwrup_go;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val, tmr_cnt;

  nvs_hw_req_filter #(.MIN_CYC(HW_MIN_CYC)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .hw_n (hw_store_n),
    .req  (hw_req)
  );

  nvs_dirty_flag u_dirty (
    .clk   (clk),
    .rst   (rst),
    .wr    (sram_we),
    .lock  (io_lock),
    .clr   (op_done),
    .dirty (dirty_q)
  );

  nvs_op_timer #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_cnt),
    .expired  (tmr_exp)
  );

  assign hw_any   = hw_pend_q | hw_req;
  assign op_done  = tmr_exp && ((state_q == ST_STORE) || (state_q == ST_RECALL) ||
                                ((state_q == ST_PWRUP) && !low_vdd));
  assign pwrup_go = (state_q == ST_PWRUP) && !low_vdd && (tmr_cnt == TW'(PWRUP_CYC - 1));

  // next-state selection; ready-state triggers in fixed priority
  always_comb begin
    state_n  = state_q;
    pend_clr = 1'b0;
    unique case (state_q)
      ST_PWRUP: if (!low_vdd && tmr_exp) state_n = ST_READY;
      ST_READY: begin
        pend_clr = 1'b1;
        if (low_vdd)
          state_n = dirty_q ? ST_STORE : ST_PWRUP;
        else if (hw_any)
          state_n = dirty_q ? ST_GRACE : ST_READY;
        else if (sw_store)
          state_n = dirty_q ? ST_STORE : ST_READY;
        else if (sw_recall)
          state_n = ST_RECALL;
      end
      ST_GRACE: if (tmr_exp) state_n = ST_STORE;
      ST_STORE, ST_RECALL: if (tmr_exp) state_n = low_vdd ? ST_PWRUP : ST_READY;
      default: state_n = ST_READY;
    endcase
  end

  assign tmr_load = (state_n != state_q) || ((state_q == ST_PWRUP) && low_vdd);

  always_comb begin
    unique case (state_n)
      ST_GRACE:  tmr_val = TW'(GRACE_CYC - 1);
      ST_STORE:  tmr_val = TW'(STORE_CYC - 1);
      ST_RECALL: tmr_val = TW'(RECALL_CYC - 1);
      ST_PWRUP:  tmr_val = TW'(PWRUP_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_PWRUP;
      hw_pend_q    <= 1'b0;
      busy         <= 1'b1;
      io_lock      <= 1'b1;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      state_q      <= state_n;
      hw_pend_q    <= pend_clr ? 1'b0 : (hw_pend_q | hw_req);
      busy         <= (state_n != ST_READY);
      io_lock      <= locks_io(state_n);
      store_start  <= (state_n == ST_STORE) && (state_q != ST_STORE);
      recall_start <= ((state_n == ST_RECALL) && (state_q != ST_RECALL)) || pwrup_go;
    end
  end
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker (
  input logic                clk,
  input logic                rst,
  input logic                hw_store_n,
  input logic                sram_we,
  input logic                io_lock,
  input logic                busy,
  input logic                store_start,
  input logic                recall_start,
  input logic                dirty,
  input logic                hw_req,
  input nvs_pkg::nvs_state_e state
);
  assert_lock_in_busy_R13: assert property (@(posedge clk) disable iff (rst)
    io_lock |-> busy);
  assert_single_start_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_start, recall_start}));
  assert_store_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    store_start |=> !store_start);
  assert_store_needs_dirty_R5: assert property (@(posedge clk) disable iff (rst)
    store_start |-> $past(dirty));
  assert_store_locked_R4: assert property (@(posedge clk) disable iff (rst)
    store_start |-> io_lock && busy);
  assert_recall_locked_R6: assert property (@(posedge clk) disable iff (rst)
    recall_start |-> io_lock && busy);
  assert_grace_open_R8: assert property (@(posedge clk) disable iff (rst)
    (state == nvs_pkg::ST_GRACE) |-> busy && !io_lock);
  assert_lock_no_store_R11: assert property (@(posedge clk) disable iff (rst)
    io_lock |=> !store_start);
  assert_hw_req_low_R7: assert property (@(posedge clk) disable iff (rst)
    hw_req |-> $past(!hw_store_n));
  assert_hw_req_once_R7: assert property (@(posedge clk) disable iff (rst)
    hw_req |=> !hw_req);
  assert_write_marks_R3: assert property (@(posedge clk) disable iff (rst)
    (sram_we && !io_lock) |=> dirty);
endmodule

bind nv_store_seq nvs_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .hw_store_n   (hw_store_n),
  .sram_we      (sram_we),
  .io_lock      (io_lock),
  .busy         (busy),
  .store_start  (store_start),
  .recall_start (recall_start),
  .dirty        (dirty_q),
  .hw_req       (hw_req),
  .state        (state_q)
);

// File: tb/tb_nv_store_seq.sv
`timescale 1ns/1ps
module tb_nv_store_seq;
  localparam int GRACE  = 6;
  localparam int STORE  = 20;
  localparam int RECALL = 12;
  localparam int PWRUP  = 16;
  localparam int HWMIN  = 3;
  localparam int IDLE   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic low_vdd = 1'b1, hw_store_n = 1'b1, sw_store = 1'b0, sw_recall = 1'b0, sram_we = 1'b0;
  logic io_lock, busy, store_start, recall_start;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nv_store_seq #(.GRACE_CYC(GRACE), .STORE_CYC(STORE), .RECALL_CYC(RECALL),
                 .PWRUP_CYC(PWRUP), .HW_MIN_CYC(HWMIN)) dut (
    .clk(clk), .rst(rst), .low_vdd(low_vdd), .hw_store_n(hw_store_n),
    .sw_store(sw_store), .sw_recall(sw_recall), .sram_we(sram_we),
    .io_lock(io_lock), .busy(busy), .store_start(store_start), .recall_start(recall_start));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // port-level monitor: own dirty mark from writes and lock releases
  bit bdirty = 1'b0, lock_prev = 1'b1;
  always @(posedge clk) begin
    #2;
    if (rst) begin
      bdirty = 1'b0;
      lock_prev = 1'b1;
    end else begin
      automatic bit dprev = bdirty;
      if (sram_we && !lock_prev) bdirty = 1'b1;
      if (lock_prev && !io_lock) bdirty = 1'b0;
      if (store_start) check("R5 store without prior write", int'(dprev), 1);
      if (io_lock && !busy) check("R13 lock outside busy", 0, 1);
      if (store_start && recall_start) check("R13 both starts", 0, 1);
      lock_prev = io_lock;
    end
  end

  task automatic pulse_store();
    sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
  endtask
  task automatic pulse_recall();
    sw_recall = 1'b1; @(negedge clk); sw_recall = 1'b0;
  endtask
  task automatic do_write();
    sram_we = 1'b1; @(negedge clk); sram_we = 1'b0;
  endtask
  task automatic hw_pulse(input int w);
    hw_store_n = 1'b0; repeat (w) @(negedge clk); hw_store_n = 1'b1;
  endtask

  // measure one operation from the current sample onward
  task automatic run_op(output int pre, output int len, output int lk, output int gr,
                        output int st_at, output int rc_at);
    pre = 0; len = 0; lk = 0; gr = 0; st_at = 0; rc_at = 0;
    while (!busy && pre < IDLE) begin
      if (store_start) st_at = -1;
      if (recall_start) rc_at = -1;
      pre++;
      @(negedge clk);
    end
    while (busy && len < 1000) begin
      len++;
      if (io_lock) lk++; else gr++;
      if (store_start && st_at == 0) st_at = len;
      if (recall_start && rc_at == 0) rc_at = len;
      @(negedge clk);
    end
  endtask

  initial begin
    #(150000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int pre, len, lk, gr, st, rc, hw_left;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 1);
    check("R1 lock in reset", int'(io_lock), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 1);
    check("R1 lock after reset", int'(io_lock), 1);
    check("R1 no starts", int'(store_start | recall_start), 0);
    repeat (4) @(negedge clk);
    check("R2 held while supply low", int'(busy), 1);
    check("R2 no pulse while low", int'(recall_start), 0);

    low_vdd = 1'b0; @(negedge clk);
    run_op(pre, len, lk, gr, st, rc);
    check("R2 powerup busy length", len, PWRUP - 1);
    check("R2 powerup pulse", rc, 1);
    check("R2 powerup locked", lk, PWRUP - 1);

    pulse_store(); run_op(pre, len, lk, gr, st, rc);
    check("R5 clean sw store skipped", pre, IDLE);
    check("R5 clean sw store no pulse", st, 0);

    do_write(); pulse_store(); run_op(pre, len, lk, gr, st, rc);
    check("R4 store pulse", st, 1);
    check("R4 store length", len, STORE);
    check("R4 store locked", lk, STORE);

    hw_pulse(HWMIN); run_op(pre, len, lk, gr, st, rc);
    check("R5 clean hw store skipped", pre, IDLE);

    do_write(); hw_pulse(HWMIN - 1); run_op(pre, len, lk, gr, st, rc);
    check("R7 short hw pulse ignored", pre, IDLE);

    hw_pulse(HWMIN); run_op(pre, len, lk, gr, st, rc);
    check("R8 grace opens one edge after request", pre, 1);
    check("R8 grace length", gr, GRACE);
    check("R8 store after grace", st, GRACE + 1);
    check("R8 store length", lk, STORE);

    pulse_recall(); run_op(pre, len, lk, gr, st, rc);
    check("R6 recall pulse", rc, 1);
    check("R6 recall length", len, RECALL);
    check("R6 recall locked", lk, RECALL);

    pulse_recall();
    sram_we = 1'b1; repeat (2) @(negedge clk); sram_we = 1'b0;
    pulse_store();
    hw_pulse(HWMIN);
    run_op(pre, len, lk, gr, st, rc);
    run_op(pre, len, lk, gr, st, rc);
    check("R10 held hw request dropped when clean", pre, IDLE);
    check("R11 store strobe during recall ignored", st, 0);
    pulse_store(); run_op(pre, len, lk, gr, st, rc);
    check("R3 locked write ignored", pre, IDLE);

    do_write(); pulse_store();
    pulse_recall();
    run_op(pre, len, lk, gr, st, rc);
    check("R11 rest of store", len, STORE - 1);
    run_op(pre, len, lk, gr, st, rc);
    check("R11 recall strobe during store ignored", pre, IDLE);
    check("R11 no recall pulse", rc, 0);

    do_write();
    sw_store = 1'b1; sw_recall = 1'b1; @(negedge clk); sw_store = 1'b0; sw_recall = 1'b0;
    run_op(pre, len, lk, gr, st, rc);
    check("R12 store wins over recall", st, 1);
    check("R12 no recall", rc, 0);
    check("R12 store length", len, STORE);

    do_write();
    low_vdd = 1'b1; @(negedge clk);
    check("R9 auto store pulse", int'(store_start), 1);
    repeat (STORE + 4) @(negedge clk);
    check("R9 locked until supply returns", int'(io_lock & busy), 1);
    low_vdd = 1'b0; @(negedge clk);
    run_op(pre, len, lk, gr, st, rc);
    check("R9 recall after supply return", rc, 1);
    check("R9 recall length", len, PWRUP - 1);

    low_vdd = 1'b1; @(negedge clk);
    check("R9 clean supply loss locks", int'(io_lock), 1);
    check("R9 clean supply loss no store", int'(store_start), 0);
    repeat (3) @(negedge clk);
    low_vdd = 1'b0; @(negedge clk);
    check("R2 first pulse", int'(recall_start), 1);
    repeat (3) @(negedge clk);
    low_vdd = 1'b1; @(negedge clk);
    low_vdd = 1'b0; @(negedge clk);
    check("R2 restart pulse", int'(recall_start), 1);
    run_op(pre, len, lk, gr, st, rc);
    check("R2 restarted length", len, PWRUP - 1);

    // constrained random traffic; monitor checks stores against writes
    hw_left = 0;
    for (int i = 0; i < 4000; i++) begin
      sram_we   = ($urandom_range(99) < 20);
      sw_store  = ($urandom_range(99) < 3);
      sw_recall = ($urandom_range(99) < 2);
      if (hw_left == 0 && $urandom_range(99) < 2) hw_left = $urandom_range(5, 1);
      hw_store_n = (hw_left == 0);
      if (hw_left > 0) hw_left--;
      @(negedge clk);
    end
    sram_we = 1'b0; sw_store = 1'b0; sw_recall = 1'b0; hw_store_n = 1'b1;
    repeat (GRACE + STORE + RECALL + 8) @(negedge clk);
    check("R13 idle after traffic", int'(busy), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule